// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block gives a host access to a wide internal register space through a two-word window. One word is a 32-bit data register. The other is a command register. It holds a 16-bit target address, a direction select, a start bit that always reads back as zero, and a busy flag that the host polls.

To write a target register, the host first loads the data word. It then writes the command word with the direction set to write and the start bit set. To read, the host waits for busy to be clear and issues the command with the direction set to read. When busy clears again, the host reads the data word.

On the inside, the block drives one request/acknowledge transaction at a time toward the target bus. It holds the address, direction and write data steady until the target acknowledges.

Top module: `ind_reg_bridge`

## Requirements
- R1: While reset is asserted, the data word and the command word both read as zero, and no target request is raised.
- R2: A host write to the command word (host_sel=1) with bit 25 set, while busy is clear, makes busy (bit 31 of the command word) read 1 from the next cycle. In that same cycle tgt_req is 1, tgt_addr equals bits 15:0 of the written value, and tgt_we equals bit 24 of the written value (1 means write, 0 means read).
- R3: Bit 25 of the command word always reads back as 0.
- R4: A command write with bit 25 clear updates the stored address and direction but starts no transaction.
- R5: During a write transaction, tgt_wdata carries the data word. The request, address, direction and write data stay unchanged until tgt_ack.
- R6: For a read transaction, the data word (host_sel=0) holds the value presented on tgt_rdata together with tgt_ack. That value is readable once busy reads 0.
- R7: Busy and tgt_req fall in the cycle after the cycle in which tgt_ack is high. With an acknowledge delay of L cycles after the request appears, busy reads 1 for exactly L+1 cycles.
- R8: While busy is set, host writes to the data word and to the command word are ignored and start no further transaction.
- R9: tgt_ack while no request is pending has no effect on busy, on the data word, or on tgt_req.
- R10: A write transaction leaves the data word unchanged.
- R11: The command word reads as busy in bit 31, direction in bit 24, address in bits 15:0, and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_we | input | 1 | Host write strobe, one cycle per write |
| host_sel | input | 1 | Window select: 0 data word, 1 command word |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Selected window word, combinational from host_sel |
| tgt_req | output | 1 | Target request, held until acknowledged |
| tgt_we | output | 1 | Target direction: 1 write, 0 read |
| tgt_addr | output | ADDR_W | Target register address |
| tgt_wdata | output | 32 | Target write value |
| tgt_ack | input | 1 | Target acknowledge, one cycle |
| tgt_rdata | input | 32 | Target read value, valid with tgt_ack |

## Verification
A command write takes effect on the rising edge where host_we is sampled. Busy and the request become visible from the next falling edge, so the bench samples half a cycle after each falling edge. The bench target model acknowledges L cycles after it first sees the request. The bench counts falling edges until busy reads 0 and expects exactly L+1, sweeping L from 0 to 3 over a spread of addresses. Read data is compared only once busy has cleared, because it is captured on the same edge that ends the transaction. For the cases where writes or acknowledges must be ignored, the bench reads both window words back and also checks the number of writes the target has seen.

// File: rtl/ibr_pkg.sv
`timescale 1ns/1ps
package ibr_pkg;
  // Window word width and command-word bit positions the host depends on
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BUSY_BIT = 31;
  localparam int unsigned GO_BIT   = 25;
  localparam int unsigned DIR_BIT  = 24;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ibr_state_e;
endpackage

// File: rtl/ibr_host_regs.sv
`timescale 1ns/1ps
module ibr_host_regs
  import ibr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [WORD_W-1:0] cap_data,
  output logic [WORD_W-1:0] data_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              dir_q,
  output logic              go
);
  logic              data_ld;
  logic              ctrl_ld;
  logic [WORD_W-1:0] data_d;
  logic [ADDR_W-1:0] addr_d;
  logic              dir_d;
  logic              unused_wr;

  assign unused_wr = ^wr_data;

  // Host writes are locked out while a transaction is outstanding
  always_comb begin
    data_ld = wr_en && !wr_sel && !busy;
    ctrl_ld = wr_en &&  wr_sel && !busy;
    go      = ctrl_ld && wr_data[GO_BIT];
    data_d  = data_q;
    if (data_ld)     data_d = wr_data;
    else if (cap_en) data_d = cap_data;
    addr_d = addr_q;
    dir_d  = dir_q;
    if (ctrl_ld) begin
      addr_d = wr_data[ADDR_W-1:0];
      dir_d  = wr_data[DIR_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      addr_q <= '0;
      dir_q  <= 1'b0;
    end else begin
      if (data_ld || cap_en) data_q <= data_d;
      if (ctrl_ld) begin
        addr_q <= addr_d;
        dir_q  <= dir_d;
      end
    end
  end

  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !cap_en) |=> ($stable(data_q) && $stable(addr_q) && $stable(dir_q)));

  // R6
  read_capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cap_en |=> (data_q == $past(cap_data)));
endmodule

// File: rtl/ibr_txn_fsm.sv
`timescale 1ns/1ps
module ibr_txn_fsm
  import ibr_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic go,
  input  logic ack,
  input  logic dir_q,
  output logic busy,
  output logic req,
  output logic cap_en
);
  ibr_state_e st_q;
  ibr_state_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (go)  st_d = ST_WAIT;
      ST_WAIT: if (ack) st_d = ST_IDLE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy   = (st_q == ST_WAIT);
  assign req    = busy;
  assign cap_en = busy && ack && !dir_q;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && go) |=> busy);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && ack) |=> !busy);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!busy && !go) |=> !busy);
endmodule

// File: rtl/ibr_rd_mux.sv
`timescale 1ns/1ps
module ibr_rd_mux
  import ibr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              sel,
  input  logic [WORD_W-1:0] data_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              dir_q,
  input  logic              busy,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] ctrl_word;

  // Start bit is never stored, so it always reads back as zero
  always_comb begin
    ctrl_word                = '0;
    ctrl_word[ADDR_W-1:0]    = addr_q;
    ctrl_word[DIR_BIT]       = dir_q;
    ctrl_word[BUSY_BIT]      = busy;
    rdata = sel ? ctrl_word : data_q;
  end
endmodule

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_sel,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic [WORD_W-1:0] tgt_wdata,
  input  logic              tgt_ack,
  input  logic [WORD_W-1:0] tgt_rdata
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ni;
  logic                   busy;
  logic                   go;
  logic                   cap_en;
  logic                   dir_q;
  logic [ADDR_W-1:0]      addr_q;
  logic [WORD_W-1:0]      data_q;

  // Asserts at once, releases after SYNC_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[SYNC_STAGES-1];

  ibr_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_en    (host_we),
    .wr_sel   (host_sel),
    .wr_data  (host_wdata),
    .busy     (busy),
    .cap_en   (cap_en),
    .cap_data (tgt_rdata),
    .data_q   (data_q),
    .addr_q   (addr_q),
    .dir_q    (dir_q),
    .go       (go)
  );

  ibr_txn_fsm u_fsm (
    .clk    (clk),
    .rst_ni (rst_ni),
    .go     (go),
    .ack    (tgt_ack),
    .dir_q  (dir_q),
    .busy   (busy),
    .req    (tgt_req),
    .cap_en (cap_en)
  );

  ibr_rd_mux #(.ADDR_W(ADDR_W)) u_mux (
    .sel    (host_sel),
    .data_q (data_q),
    .addr_q (addr_q),
    .dir_q  (dir_q),
    .busy   (busy),
    .rdata  (host_rdata)
  );

  assign tgt_we    = dir_q;
  assign tgt_addr  = addr_q;
  assign tgt_wdata = data_q;

  // R5
  req_steady_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tgt_req && !tgt_ack) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_we)
                               && $stable(tgt_wdata)));
endmodule

// File: tb/ind_reg_bridge_test.sv
`timescale 1ns/1ps
module ind_reg_bridge_test;
  logic        clk;
  logic        rst_n;
  logic        host_we;
  logic        host_sel;
  logic [31:0] host_wdata;
  logic [31:0] host_rdata;
  logic        tgt_req;
  logic        tgt_we;
  logic [15:0] tgt_addr;
  logic [31:0] tgt_wdata;
  logic        tgt_ack;
  logic [31:0] tgt_rdata;

  int checks;
  int errs;
  int lat_cfg;
  int cnt;
  int wr_seen;
  bit spur;
  logic [31:0] tmem   [16];
  logic [31:0] expmem [16];

  ind_reg_bridge uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tgt_req(tgt_req),
    .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .tgt_ack(tgt_ack), .tgt_rdata(tgt_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] seed_val(input int i);
    return 32'hC3A5_0000 | (32'(i) * 32'h0000_0101);
  endfunction

  // Target model: acknowledges lat_cfg cycles after it first sees a request
  always @(negedge clk) begin
    if (tgt_ack) begin
      tgt_ack = 1'b0;
    end else if (tgt_req) begin
      if (cnt >= lat_cfg) begin
        tgt_ack = 1'b1;
        cnt = 0;
        if (tgt_we) begin
          tmem[tgt_addr[3:0]] = tgt_wdata;
          wr_seen++;
        end else begin
          tgt_rdata = tmem[tgt_addr[3:0]];
        end
      end else begin
        cnt++;
      end
    end else if (spur) begin
      tgt_ack   = 1'b1;
      tgt_rdata = 32'hDEAD_BEEF;
      spur      = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic s, input logic [31:0] d);
    host_we = 1'b1; host_sel = s; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    #0.5;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [31:0] v);
    host_sel = s;
    #0.2;
    v = host_rdata;
  endtask

  task automatic do_txn(input logic [15:0] a, input logic isw, input logic [31:0] wd);
    logic [31:0] v;
    int cyc;
    if (isw) host_write(1'b0, wd);
    host_write(1'b1, {6'b0, 1'b1, isw, 8'b0, a});
    rd(1'b1, v);
    chk("R2 busy after start", {31'b0, v[31]}, 32'd1);
    chk("R2 request raised", {31'b0, tgt_req}, 32'd1);
    chk("R2 target address", {16'b0, tgt_addr}, {16'b0, a});
    chk("R2 target direction", {31'b0, tgt_we}, {31'b0, isw});
    if (isw) chk("R5 target write data", tgt_wdata, wd);
    cyc = 0;
    while (v[31] && cyc < 40) begin
      @(negedge clk); #0.5;
      rd(1'b1, v);
      cyc++;
    end
    chk("R7 busy duration", 32'(cyc), 32'(lat_cfg + 1));
    chk("R7 request dropped", {31'b0, tgt_req}, 32'd0);
    chk("R3 R11 command readback", v, {7'b0, isw, 8'b0, a});
    rd(1'b0, v);
    if (isw) begin
      expmem[a[3:0]] = wd;
      chk("R10 data word kept", v, wd);
    end else begin
      chk("R6 read data", v, expmem[a[3:0]]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired (R7): actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [31:0] keep;
    int wrs;
    checks = 0; errs = 0; lat_cfg = 0; cnt = 0; wr_seen = 0; spur = 1'b0;
    rst_n = 1'b0; host_we = 1'b0; host_sel = 1'b0; host_wdata = '0;
    tgt_ack = 1'b0; tgt_rdata = '0;
    for (int i = 0; i < 16; i++) begin
      tmem[i]   = seed_val(i);
      expmem[i] = seed_val(i);
    end
    repeat (3) @(negedge clk);
    #0.5;
    rd(1'b0, v); chk("R1 data word in reset", v, 32'd0);
    rd(1'b1, v); chk("R1 command word in reset", v, 32'd0);
    chk("R1 no request in reset", {31'b0, tgt_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #0.5;

    // Sweep acknowledge delay and addresses: read seeded, write, read back
    for (int lat = 0; lat < 4; lat++) begin
      lat_cfg = lat;
      for (int k = 0; k < 6; k++) begin
        logic [15:0] a;
        a = (k == 5) ? 16'hFFFF : 16'((k * 16'h2493) + lat);
        do_txn(a, 1'b0, 32'd0);
        do_txn(a, 1'b1, 32'((lat << 20) ^ (k * 32'h0101_0011) ^ 32'hF0F0_0F0F));
        do_txn(a, 1'b0, 32'd0);
      end
    end

    // R8: writes during a pending transaction are ignored
    lat_cfg = 3;
    host_write(1'b0, 32'h1357_9BDF);
    wrs = wr_seen;
    host_write(1'b1, {6'b0, 1'b1, 1'b1, 8'b0, 16'h00A3});
    host_write(1'b0, 32'hFFFF_0000);
    host_write(1'b1, {6'b0, 1'b1, 1'b0, 8'b0, 16'h0B0E});
    rd(1'b1, v);
    while (v[31]) begin @(negedge clk); #0.5; rd(1'b1, v); end
    chk("R8 command word unchanged", v, 32'h0100_00A3);
    rd(1'b0, v);
    chk("R8 data word unchanged", v, 32'h1357_9BDF);
    repeat (4) @(negedge clk);
    #0.5;
    chk("R8 no second request", {31'b0, tgt_req}, 32'd0);
    chk("R8 single target write", 32'(wr_seen), 32'(wrs + 1));
    expmem[3] = 32'h1357_9BDF;

    // R9: stray acknowledge while idle
    rd(1'b0, keep);
    spur = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    rd(1'b0, v); chk("R9 data word after stray ack", v, keep);
    rd(1'b1, v); chk("R9 busy after stray ack", {31'b0, v[31]}, 32'd0);
    chk("R9 no request after stray ack", {31'b0, tgt_req}, 32'd0);

    // R4: command write without start bit
    wrs = wr_seen;
    host_write(1'b1, {7'b0, 1'b1, 8'b0, 16'h4321});
    rd(1'b1, v); chk("R4 command stored", v, 32'h0100_4321);
    chk("R4 no request", {31'b0, tgt_req}, 32'd0);
    repeat (3) @(negedge clk);
    #0.5;
    chk("R4 still no request", {31'b0, tgt_req}, 32'd0);
    chk("R4 target untouched", 32'(wr_seen), 32'(wrs));

    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule